// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is the device side of an asynchronous, page-mode DRAM, turned into synchronous logic. A fast oversampling clock samples the row strobe, column strobe, write enable, output enable, the shared address pins and the input data. The block works out from the order of the strobe edges what kind of cycle the memory controller is running. It latches the row and column addresses, reads and writes a small internal byte array, and drives the read data together with an output-enable flag. Nothing here measures analog timing: only the order of the edges matters.

Refresh is modelled. A falling row strobe with the column strobe high refreshes the row on the address pins. A falling row strobe with the column strobe already low refreshes the row held in an internal 10-bit counter, which then advances. A tracker records when each modelled row was last refreshed and raises a sticky retention error once any row has gone a parameterised number of clocks without one. A testbench of a DRAM controller can connect this block in place of a memory device and check both the data and the refresh schedule.

The pin interface keeps 10 row bits and 9 column bits on one shared address bus. The internal array decodes only the low bits of each, so rows and columns alias modulo the array size.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset the cycle kind is standby (0), the output enable and the refresh strobe are low, the retention error is low and the refresh counter is 0.
- R2: A row strobe fall while the column strobe is already low starts a CAS-before-RAS refresh, kind 6. The refreshed row is the counter value, and the counter then increments, wrapping from 1023 to 0. The address pins are ignored and the output stays off.
- R3: A row strobe fall while the column strobe is high latches the row from the address pins and reports kind 5 (RAS-only) until a column strobe falls. The output stays off.
- R4: A column strobe fall with write enable high is a read, kind 1, of the latched row and column. The data is driven only while output enable is low, and taking output enable high turns the output off.
- R5: If write enable is already low when the column strobe falls, the cycle is an early write, kind 2. The input data is stored and the output stays off.
- R6: Write enable falling after the column strobe, during a read, stores the input data. The cycle is a late write, kind 3, if no data was driven before, or a read-modify-write, kind 4, if read data was already driven.
- R7: A row strobe that goes high and then low again while the column strobe stays low after a read is a hidden refresh, kind 7. It refreshes the counter row, and the same read data stays on the output.
- R8: The output turns off once the row and column strobes are both high, and the kind then returns to standby.
- R9: Every row strobe fall gives a one-clock refresh strobe with the refreshed 10-bit row, so reads and writes also refresh their row.
- R10: Several column strobe pulses within one row strobe low period (page mode) all use the latched row. The array decodes only the low row and column address bits.
- R11: The retention error rises and stays high once any modelled row has gone RETAIN_CYC clocks without a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Shared row/column address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero while not driven |
| dout_en | output | 1 | High while the data output is driven |
| cycle_kind | output | 3 | Cycle kind: 0 standby, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 RAS-only, 6 CAS-before-RAS, 7 hidden refresh |
| ref_valid | output | 1 | One-clock pulse for each row refresh |
| ref_row | output | 10 | Row refreshed with ref_valid |
| retention_err | output | 1 | Sticky flag: some row missed its refresh window |

## Verification
The bench targets the edge orderings that separate one cycle kind from another.

- **Early or late write.** Write enable is placed before the column strobe in one test and after it in another. A decoder that looks only at levels would mistake a late write for an early one, or would drive data during an early write.
- **Late write or read-modify-write.** The same late write is run with and without a read that reaches the output first. A design that ignores whether data was driven reports the wrong one of the two.
- **Hidden refresh.** Hidden refresh keeps the column strobe low across a row strobe toggle. A design that cleared the output on the row strobe rise, or that refreshed the address-pin row instead of the counter row, fails the data check or the refresh scoreboard.
- **Counter wrap and retention.** The refresh counter is run through its full wrap. The retention window is then allowed to lapse, so a tracker that never fires, or fires early, is caught.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [2:0] {
        K_STANDBY  = 3'd0,
        K_READ     = 3'd1,
        K_EARLY_WR = 3'd2,
        K_LATE_WR  = 3'd3,
        K_RMW      = 3'd4,
        K_RAS_ONLY = 3'd5,
        K_CBR      = 3'd6,
        K_HIDDEN   = 3'd7
    } cyc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // row strobe high
        PH_ROW  = 2'd1,   // row open for access
        PH_REF  = 2'd2    // counter-addressed refresh in progress
    } phase_e;

    // pin levels as sampled (1 = electrically high)
    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobes_t;

endpackage

// File: rtl/dsd_pin_sampler.sv
module dsd_pin_sampler
    import dsd_pkg::*;
#(
    parameter int PIN_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [PIN_W-1:0]  addr,
    input  logic [DATA_W-1:0] din,
    output strobes_t          lvl,
    output logic [PIN_W-1:0]  s_addr,
    output logic [DATA_W-1:0] s_din,
    output logic              ras_fall,
    output logic              ras_rise,
    output logic              cas_fall,
    output logic              cas_rise,
    output logic              we_fall
);

    typedef struct packed {
        strobes_t          cur;
        logic              p_ras;
        logic              p_cas;
        logic              p_we;
        logic [PIN_W-1:0]  addr;
        logic [DATA_W-1:0] din;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d        = smp_q;
        smp_d.cur    = '{ras: ras_n, cas: cas_n, we: we_n, oe: oe_n};
        smp_d.p_ras  = smp_q.cur.ras;
        smp_d.p_cas  = smp_q.cur.cas;
        smp_d.p_we   = smp_q.cur.we;
        smp_d.addr   = addr;
        smp_d.din    = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q     <= '0;
            smp_q.cur <= '{ras: 1'b1, cas: 1'b1, we: 1'b1, oe: 1'b1};
            smp_q.p_ras <= 1'b1;
            smp_q.p_cas <= 1'b1;
            smp_q.p_we  <= 1'b1;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign lvl      = smp_q.cur;
    assign s_addr   = smp_q.addr;
    assign s_din    = smp_q.din;
    assign ras_fall =  smp_q.p_ras & ~smp_q.cur.ras;
    assign ras_rise = ~smp_q.p_ras &  smp_q.cur.ras;
    assign cas_fall =  smp_q.p_cas & ~smp_q.cur.cas;
    assign cas_rise = ~smp_q.p_cas &  smp_q.cur.cas;
    assign we_fall  =  smp_q.p_we  & ~smp_q.cur.we;

endmodule

// File: rtl/dsd_cell_array.sv
module dsd_cell_array #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/dsd_retention_tracker.sv
module dsd_retention_tracker #(
    parameter int IDX_W = 3,
    parameter int LIMIT = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_valid,
    input  logic [IDX_W-1:0] refresh_idx,
    output logic             err
);

    localparam int ROWS  = 1 << IDX_W;
    localparam int AGE_W = $clog2(LIMIT + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(LIMIT);

    logic [AGE_W-1:0] age_d [ROWS];
    logic [AGE_W-1:0] age_q [ROWS];
    logic             err_d, err_q;

    always_comb begin
        err_d = err_q;
        for (int r = 0; r < ROWS; r++) begin
            if (refresh_valid && refresh_idx == IDX_W'(r)) begin
                age_d[r] = '0;
            end else if (age_q[r] == AGE_MAX) begin
                age_d[r] = age_q[r];
            end else begin
                age_d[r] = age_q[r] + 1'b1;
            end
            if (age_q[r] == AGE_MAX) begin
                err_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
        for (int r = 0; r < ROWS; r++) begin
            if (!rst_n) begin
                age_q[r] <= '0;
            end else begin
                age_q[r] <= age_d[r];
            end
        end
    end

    assign err = err_q;

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
    import dsd_pkg::*;
#(
    parameter int ROW_W        = 10,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 8,
    parameter int ARR_ROW_BITS = 3,
    parameter int ARR_COL_BITS = 3,
    parameter int REFCNT_W     = 10,
    parameter int RETAIN_CYC   = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ROW_W-1:0]  addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic [2:0]        cycle_kind,
    output logic              ref_valid,
    output logic [ROW_W-1:0]  ref_row,
    output logic              retention_err
);

    localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int IDX_W = ARR_ROW_BITS + ARR_COL_BITS;

    typedef struct packed {
        phase_e                  phase;
        logic                    acc;       // column strobe access active
        logic                    acc_wr;    // current access has written
        logic                    seen;      // read data reached the output
        logic                    rd_valid;  // read data held for output
        logic [ARR_ROW_BITS-1:0] row;
        logic [ARR_COL_BITS-1:0] col;
        logic [REFCNT_W-1:0]     cnt;
        logic                    ref_valid;
        logic [ROW_W-1:0]        ref_row;
        cyc_kind_e               kind;
        logic [DATA_W-1:0]       dout;
        logic                    dout_en;
    } st_t;

    st_t st_d, st_q;

    strobes_t          lvl;
    logic [PIN_W-1:0]  s_addr;
    logic [DATA_W-1:0] s_din;
    logic              ras_fall, ras_rise, cas_fall, cas_rise, we_fall;

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic [REFCNT_W-1:0] ref_cnt_w;

    dsd_pin_sampler #(
        .PIN_W  (PIN_W),
        .DATA_W (DATA_W)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (PIN_W'(addr)),
        .din      (din),
        .lvl      (lvl),
        .s_addr   (s_addr),
        .s_din    (s_din),
        .ras_fall (ras_fall),
        .ras_rise (ras_rise),
        .cas_fall (cas_fall),
        .cas_rise (cas_rise),
        .we_fall  (we_fall)
    );

    dsd_cell_array #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (s_din),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    dsd_retention_tracker #(
        .IDX_W (ARR_ROW_BITS),
        .LIMIT (RETAIN_CYC)
    ) u_retain (
        .clk           (clk),
        .rst_n         (rst_n),
        .refresh_valid (st_q.ref_valid),
        .refresh_idx   (st_q.ref_row[ARR_ROW_BITS-1:0]),
        .err           (retention_err)
    );

    // column index for an access starting this sample
    assign rd_idx = {st_q.row, s_addr[ARR_COL_BITS-1:0]};

    always_comb begin
        st_d           = st_q;
        st_d.ref_valid = 1'b0;
        wr_en          = 1'b0;
        wr_idx         = rd_idx;

        if (st_q.dout_en && st_q.acc) begin
            st_d.seen = 1'b1;
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (ras_fall) begin
                    st_d.ref_valid = 1'b1;
                    st_d.acc       = 1'b0;
                    st_d.acc_wr    = 1'b0;
                    if (!lvl.cas) begin
                        // counter-addressed refresh; pins ignored
                        st_d.ref_row = ROW_W'(st_q.cnt);
                        st_d.cnt     = st_q.cnt + 1'b1;
                        st_d.kind    = st_q.rd_valid ? K_HIDDEN : K_CBR;
                        st_d.phase   = PH_REF;
                    end else begin
                        st_d.ref_row  = s_addr[ROW_W-1:0];
                        st_d.row      = s_addr[ARR_ROW_BITS-1:0];
                        st_d.kind     = K_RAS_ONLY;
                        st_d.rd_valid = 1'b0;
                        st_d.phase    = PH_ROW;
                    end
                end else if (lvl.ras && lvl.cas) begin
                    st_d.kind = K_STANDBY;
                end
            end
            PH_ROW: begin
                if (ras_rise) begin
                    st_d.phase = PH_IDLE;
                    st_d.acc   = 1'b0;
                end else if (cas_fall) begin
                    st_d.acc  = 1'b1;
                    st_d.col  = s_addr[ARR_COL_BITS-1:0];
                    st_d.seen = 1'b0;
                    if (!lvl.we) begin
                        wr_en         = 1'b1;
                        st_d.kind     = K_EARLY_WR;
                        st_d.acc_wr   = 1'b1;
                        st_d.rd_valid = 1'b0;
                    end else begin
                        st_d.kind     = K_READ;
                        st_d.acc_wr   = 1'b0;
                        st_d.rd_valid = 1'b1;
                        st_d.dout     = rd_data;
                    end
                end else if (cas_rise) begin
                    st_d.acc = 1'b0;
                end else if (we_fall && st_q.acc && !st_q.acc_wr) begin
                    wr_en         = 1'b1;
                    wr_idx        = {st_q.row, st_q.col};
                    st_d.acc_wr   = 1'b1;
                    st_d.rd_valid = 1'b0;
                    st_d.kind     = st_d.seen ? K_RMW : K_LATE_WR;
                end
            end
            PH_REF: begin
                if (ras_rise) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase

        if (lvl.ras && lvl.cas) begin
            st_d.rd_valid = 1'b0;
        end
        st_d.dout_en = st_d.rd_valid & ~lvl.oe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout       = st_q.dout_en ? st_q.dout : '0;
    assign dout_en    = st_q.dout_en;
    assign cycle_kind = st_q.kind;
    assign ref_valid  = st_q.ref_valid;
    assign ref_row    = st_q.ref_row;
    assign ref_cnt_w  = st_q.cnt;

endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
    parameter int ROW_W    = 10,
    parameter int REFCNT_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ras_n,
    input logic                cas_n,
    input logic                oe_n,
    input logic                dout_en,
    input logic [2:0]          cycle_kind,
    input logic                ref_valid,
    input logic [ROW_W-1:0]    ref_row,
    input logic [REFCNT_W-1:0] ref_cnt,
    input logic                retention_err
);

    // R8: the output is never on two samples after both strobes were high
    a_r8_off_when_both_high: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !($past(ras_n, 2) && $past(cas_n, 2)));

    // R4: data drives only with output enable low
    a_r4_oe_gates_output: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !$past(oe_n, 2));

    a_r5_early_write_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_kind == 3'd2) |-> !dout_en);

    a_r2_cbr_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_kind == 3'd6) |-> !dout_en);

    a_r3_ras_only_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_kind == 3'd5) |-> !dout_en);

    // R2: a counter refresh leaves the counter one past the reported row
    a_r2_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && (cycle_kind == 3'd6 || cycle_kind == 3'd7))
        |-> (ref_cnt == ref_row[REFCNT_W-1:0] + 1'b1));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> !ref_valid);

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        retention_err |=> retention_err);

endmodule

bind dram_strobe_decoder dsd_checker #(
    .ROW_W    (ROW_W),
    .REFCNT_W (REFCNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .oe_n          (oe_n),
    .dout_en       (dout_en),
    .cycle_kind    (cycle_kind),
    .ref_valid     (ref_valid),
    .ref_row       (ref_row),
    .ref_cnt       (ref_cnt_w),
    .retention_err (retention_err)
);

// File: tb/tb_dram_strobe_decoder.sv
module tb_dram_strobe_decoder;

    localparam int RETAIN = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [9:0] addr = '0;
    logic [7:0] din  = '0;
    logic [7:0] dout;
    logic       dout_en;
    logic [2:0] cycle_kind;
    logic       ref_valid;
    logic [9:0] ref_row;
    logic       retention_err;

    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;
    logic [9:0] exp_q[$];
    logic [9:0] cnt_model = '0;
    logic [9:0] mon_exp;

    always #4 clk = ~clk;

    dram_strobe_decoder dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .we_n          (we_n),
        .oe_n          (oe_n),
        .addr          (addr),
        .din           (din),
        .dout          (dout),
        .dout_en       (dout_en),
        .cycle_kind    (cycle_kind),
        .ref_valid     (ref_valid),
        .ref_row       (ref_row),
        .retention_err (retention_err)
    );

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: each refresh pulse must match the next expected row
    always @(negedge clk) begin
        if (rst_n && ref_valid && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9 refresh row actual=%0h expected=none", ref_row);
            end else begin
                mon_exp = exp_q.pop_front();
                if (ref_row !== mon_exp) begin
                    fails++;
                    $display("FAIL R9/R2 refresh row actual=%0h expected=%0h", ref_row, mon_exp);
                end
            end
        end
    end

    task automatic open_row(logic [9:0] row);
        addr = row;
        wait_n(1);
        ras_n = 1'b0;
        exp_q.push_back(row);
        wait_n(3);
    endtask

    task automatic close_all();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        wait_n(3);
    endtask

    task automatic cbr(bit check_it);
        addr  = 10'h3FF;
        cas_n = 1'b0;
        wait_n(2);
        ras_n = 1'b0;
        exp_q.push_back(cnt_model);
        cnt_model = cnt_model + 1'b1;
        wait_n(2);
        if (check_it) begin
            chk("R2 kind", cycle_kind, 3'd6);
            chk("R2 output off", dout_en, 1'b0);
        end
        ras_n = 1'b1;
        wait_n(2);
        cas_n = 1'b1;
        wait_n(2);
    endtask

    task automatic early_wr(logic [9:0] row, logic [9:0] col, logic [7:0] data);
        open_row(row);
        we_n = 1'b0; din = data; addr = col;
        wait_n(2);
        cas_n = 1'b0;
        wait_n(3);
        chk("R5 kind", cycle_kind, 3'd2);
        chk("R5 output off", dout_en, 1'b0);
        close_all();
    endtask

    task automatic read_chk(string req, logic [9:0] row, logic [9:0] col, logic [7:0] exp);
        open_row(row);
        addr = col;
        oe_n = 1'b0;
        cas_n = 1'b0;
        wait_n(3);
        chk({req, " data"}, dout, exp);
        close_all();
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        // R1
        chk("R1 kind", cycle_kind, 3'd0);
        chk("R1 dout_en", dout_en, 1'b0);
        chk("R1 ref_valid", ref_valid, 1'b0);
        chk("R1 retention_err", retention_err, 1'b0);

        // R2: eight counter refreshes, addresses on pins ignored
        for (int i = 0; i < 8; i++) cbr(i == 0);

        // R5 early writes
        early_wr(10'd0, 10'd0, 8'hA5);
        early_wr(10'd1, 10'd2, 8'h3C);
        early_wr(10'd5, 10'd7, 8'h81);
        early_wr(10'd3, 10'd4, 8'h11);
        chk("R8 standby kind", cycle_kind, 3'd0);

        // R4 read with OE gating, R8 release
        open_row(10'd1);
        addr = 10'd2; cas_n = 1'b0;
        wait_n(3);
        chk("R4 kind", cycle_kind, 3'd1);
        chk("R4 OE high keeps output off", dout_en, 1'b0);
        oe_n = 1'b0; wait_n(3);
        chk("R4 dout_en", dout_en, 1'b1);
        chk("R4 data", dout, 8'h3C);
        oe_n = 1'b1; wait_n(3);
        chk("R4 OE high turns output off", dout_en, 1'b0);
        oe_n = 1'b0; wait_n(3);
        ras_n = 1'b1; wait_n(3);
        chk("R8 held with CAS low", dout_en, 1'b1);
        cas_n = 1'b1; wait_n(3);
        chk("R8 off when both high", dout_en, 1'b0);
        chk("R8 kind standby", cycle_kind, 3'd0);
        oe_n = 1'b1; wait_n(2);

        // R10 page mode: read, early write, read within one row period
        open_row(10'd5);
        addr = 10'd7; cas_n = 1'b0; oe_n = 1'b0;
        wait_n(3);
        chk("R10 page read 1", dout, 8'h81);
        oe_n = 1'b1; cas_n = 1'b1; wait_n(2);
        we_n = 1'b0; din = 8'h5A; addr = 10'd3; wait_n(2);
        cas_n = 1'b0; wait_n(3);
        chk("R10 page early write kind", cycle_kind, 3'd2);
        cas_n = 1'b1; we_n = 1'b1; wait_n(2);
        addr = 10'd3; cas_n = 1'b0; oe_n = 1'b0; wait_n(3);
        chk("R10 page read kind", cycle_kind, 3'd1);
        chk("R10 page read back", dout, 8'h5A);
        close_all();
        // R10 aliasing of upper row/column bits
        read_chk("R10 alias", 10'h208, 10'h040, 8'hA5);

        // R6 late write (no data driven before WE fall)
        open_row(10'd2);
        addr = 10'd1; cas_n = 1'b0; wait_n(3);
        we_n = 1'b0; din = 8'h77; wait_n(3);
        chk("R6 late write kind", cycle_kind, 3'd3);
        chk("R6 late write output off", dout_en, 1'b0);
        close_all();
        read_chk("R6 late write stored", 10'd2, 10'd1, 8'h77);

        // R6 read-modify-write
        open_row(10'd3);
        addr = 10'd4; cas_n = 1'b0; oe_n = 1'b0; wait_n(3);
        chk("R6 rmw read part", dout, 8'h11);
        oe_n = 1'b1; wait_n(2);
        we_n = 1'b0; din = 8'hEE; wait_n(3);
        chk("R6 rmw kind", cycle_kind, 3'd4);
        close_all();
        read_chk("R6 rmw stored", 10'd3, 10'd4, 8'hEE);

        // R7 hidden refresh
        open_row(10'd0);
        addr = 10'd0; cas_n = 1'b0; oe_n = 1'b0; wait_n(3);
        ras_n = 1'b1; wait_n(3);
        addr = 10'h155;
        ras_n = 1'b0;
        exp_q.push_back(cnt_model);
        cnt_model = cnt_model + 1'b1;
        wait_n(3);
        chk("R7 kind", cycle_kind, 3'd7);
        chk("R7 output kept", dout_en, 1'b1);
        chk("R7 data kept", dout, 8'hA5);
        close_all();
        chk("R8 after hidden", dout_en, 1'b0);

        // R3 RAS-only refresh
        open_row(10'h2AB);
        chk("R3 kind", cycle_kind, 3'd5);
        chk("R3 output off", dout_en, 1'b0);
        close_all();
        chk("R11 no error yet", retention_err, 1'b0);

        // R2 counter wrap: run to 1023 then one more gives row 0
        while (cnt_model != 10'd0) cbr(1'b0);
        cbr(1'b1);
        chk("R2 wrap scoreboard drained", exp_q.size(), 0);

        // R11 retention window
        for (int i = 0; i < 8; i++) cbr(1'b0);
        wait_n(RETAIN - 100);
        chk("R11 inside window", retention_err, 1'b0);
        wait_n(200);
        chk("R11 window expired", retention_err, 1'b1);
        chk("R9 all refreshes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule